// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher

This block decides, once per second, whether the current time of day has reached a programmed alarm time. It takes six bytes as inputs: the current seconds, minutes and hours, and the three alarm bytes for the same fields. It also takes two mode bits and a strobe that marks each once-per-second update. When the strobe arrives and every field agrees, the block raises a single-cycle alarm event for the interrupt and status logic next to it.

Each byte is first turned into a plain number. In BCD mode, the upper nibble holds the tens digit and the lower nibble holds the units digit. In binary mode, the byte is used unchanged. Hours in 12-hour mode carry a PM flag in the top bit, and the block folds that flag in so that both hour bytes are compared on a 0 to 23 scale. Any alarm byte can be marked "don't care", and a marked field agrees with every current value. While the clock is frozen for setting, or while its prescaler is held, no alarm is produced.

The time bytes are expected to already hold the post-update values in the same cycle as the strobe. The alarm event appears on the clock edge that captures the strobe.

Top module: `rtc_alarm_match`

## Requirements
- R1: `alarm_o` is a registered output. It is high for exactly the one cycle after a cycle in which `tick_i` was high and the match held. It is low after any cycle in which `tick_i` was low.
- R2: An alarm byte whose bits 7 and 6 are both 1 is a don't-care and agrees with any current value of its field, in every mode. A byte with only bit 7 set is not a don't-care.
- R3: With `bin_mode_i` = 0 (BCD), each byte is worth bits[7:4] × 10 + bits[3:0]. The current and alarm values are compared after this decoding.
- R4: With `bin_mode_i` = 1, the bytes are compared as plain binary numbers. Equal current and alarm bytes always match.
- R5: With `hr24_i` = 0, bit 7 of each hour byte is the PM flag and bits [6:0] are the hour. The hour becomes (hour mod 12) + 12 when PM is set, so 12 AM equals 0 and 12 PM equals 12.
- R6: With `hr24_i` = 1, the whole hour byte is decoded and bit 7 gets no PM treatment.
- R7: A non-don't-care field whose current or alarm byte holds a BCD digit above 9 never matches in BCD mode.
- R8: No alarm is produced for a strobe that arrives while `freeze_i` is high.
- R9: No alarm is produced for a strobe that arrives while `div_hold_i` is high.
- R10: With seconds as don't-care and fixed hours and minutes, an alarm fires on every strobe within the matching minute and stops when the minute moves on.
- R11: After synchronous reset `rst`, and while it is held, `alarm_o` is 0.
- R12: With all three alarm bytes set to don't-care, every enabled strobe produces an alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Once-per-second update strobe |
| freeze_i | input | 1 | Time updates stopped for setting; suppresses alarms |
| div_hold_i | input | 1 | Prescaler held in reset; suppresses alarms |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24_i | input | 1 | 1 = 24-hour format, 0 = 12-hour with PM flag |
| cur_sec_i | input | 8 | Current seconds byte |
| cur_min_i | input | 8 | Current minutes byte |
| cur_hour_i | input | 8 | Current hours byte |
| alm_sec_i | input | 8 | Alarm seconds byte |
| alm_min_i | input | 8 | Alarm minutes byte |
| alm_hour_i | input | 8 | Alarm hours byte |
| alarm_o | output | 1 | One-cycle alarm event |

## Verification
The bench targets the hour byte in 12-hour mode, where several failure modes show up. A design that ignores the PM flag would match 1 PM against 1 AM. A design that skips the modulo would treat 12 AM as 12 and miss a match against hour 0. A design that removes the flag before the don't-care test would fail to recognise 0xFF as a don't-care. Other cases check that a byte with only bit 7 set is not a don't-care, and that an out-of-range BCD digit fails to match even when both bytes are identical, while the same bytes in binary mode do match. The remaining cases check that the freeze and prescaler-hold inputs suppress alarms, and that the output is a single pulse rather than a level that stays high.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int BYTE_W   = 8;
  localparam int NIB_W    = BYTE_W / 2;
  localparam int FIELDS   = 3;
  localparam int HOUR_IDX = FIELDS - 1;

  localparam logic [BYTE_W-1:0] PM_FLAG    = {1'b1, {(BYTE_W-1){1'b0}}};
  localparam logic [BYTE_W-1:0] HALF_DAY   = BYTE_W'(12);
  localparam logic [BYTE_W-1:0] DIGIT_BASE = BYTE_W'(10);
  localparam logic [NIB_W-1:0]  DIGIT_MAX  = NIB_W'(9);

  function automatic logic is_dont_care(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1] & b[BYTE_W-2];
  endfunction

  function automatic logic bcd_ok(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1:NIB_W] <= DIGIT_MAX) && (b[NIB_W-1:0] <= DIGIT_MAX);
  endfunction

  function automatic logic [BYTE_W-1:0] bcd_value(input logic [BYTE_W-1:0] b);
    return BYTE_W'(b[BYTE_W-1:NIB_W]) * DIGIT_BASE + BYTE_W'(b[NIB_W-1:0]);
  endfunction
endpackage

// File: rtl/rtc_alarm_decode.sv
module rtc_alarm_decode
  import rtc_alarm_pkg::*;
#(
  parameter bit HOUR_FIELD = 1'b0
) (
  input  logic [BYTE_W-1:0] raw_i,
  input  logic              bin_mode_i,
  input  logic              hr24_i,
  output logic [BYTE_W-1:0] val_o,
  output logic              ok_o
);
  logic              pm;
  logic              twelve;
  logic [BYTE_W-1:0] body;
  logic [BYTE_W-1:0] num;

  always_comb begin
    twelve = HOUR_FIELD && !hr24_i;
    pm     = twelve & raw_i[BYTE_W-1];
    body   = twelve ? (raw_i & ~PM_FLAG) : raw_i;
    if (bin_mode_i) begin
      num  = body;
      ok_o = 1'b1;
    end else begin
      num  = bcd_value(body);
      ok_o = bcd_ok(body);
    end
    if (twelve) begin
      val_o = (num % HALF_DAY) + (pm ? HALF_DAY : '0);
    end else begin
      val_o = num;
    end
  end
endmodule

// File: rtl/rtc_alarm_field.sv
module rtc_alarm_field
  import rtc_alarm_pkg::*;
#(
  parameter bit HOUR_FIELD = 1'b0
) (
  input  logic [BYTE_W-1:0] cur_i,
  input  logic [BYTE_W-1:0] alm_i,
  input  logic              bin_mode_i,
  input  logic              hr24_i,
  output logic              hit_o
);
  logic [BYTE_W-1:0] cur_v, alm_v;
  logic              cur_ok, alm_ok;

  rtc_alarm_decode #(.HOUR_FIELD(HOUR_FIELD)) u_cur (
    .raw_i(cur_i), .bin_mode_i(bin_mode_i), .hr24_i(hr24_i),
    .val_o(cur_v), .ok_o(cur_ok)
  );

  rtc_alarm_decode #(.HOUR_FIELD(HOUR_FIELD)) u_alm (
    .raw_i(alm_i), .bin_mode_i(bin_mode_i), .hr24_i(hr24_i),
    .val_o(alm_v), .ok_o(alm_ok)
  );

  always_comb begin
    hit_o = is_dont_care(alm_i) | (cur_ok & alm_ok & (cur_v == alm_v));
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              freeze_i,
  input  logic              div_hold_i,
  input  logic              bin_mode_i,
  input  logic              hr24_i,
  input  logic [BYTE_W-1:0] cur_sec_i,
  input  logic [BYTE_W-1:0] cur_min_i,
  input  logic [BYTE_W-1:0] cur_hour_i,
  input  logic [BYTE_W-1:0] alm_sec_i,
  input  logic [BYTE_W-1:0] alm_min_i,
  input  logic [BYTE_W-1:0] alm_hour_i,
  output logic              alarm_o
);
  logic [BYTE_W-1:0] cur_b [FIELDS];
  logic [BYTE_W-1:0] alm_b [FIELDS];
  logic [FIELDS-1:0] hits;
  logic              running;

  // field order: seconds, minutes, hours (hours last so it gets PM handling)
  always_comb begin
    cur_b[0] = cur_sec_i;
    cur_b[1] = cur_min_i;
    cur_b[2] = cur_hour_i;
    alm_b[0] = alm_sec_i;
    alm_b[1] = alm_min_i;
    alm_b[2] = alm_hour_i;
  end

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    rtc_alarm_field #(.HOUR_FIELD(i == HOUR_IDX)) u_field (
      .cur_i(cur_b[i]), .alm_i(alm_b[i]),
      .bin_mode_i(bin_mode_i), .hr24_i(hr24_i),
      .hit_o(hits[i])
    );
  end

  assign running = ~freeze_i & ~div_hold_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_o <= 1'b0;
    end else begin
      alarm_o <= tick_i & running & (&hits);
    end
  end
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
  import rtc_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              freeze_i,
  input logic              div_hold_i,
  input logic              bin_mode_i,
  input logic [BYTE_W-1:0] cur_sec_i,
  input logic [BYTE_W-1:0] cur_min_i,
  input logic [BYTE_W-1:0] cur_hour_i,
  input logic [BYTE_W-1:0] alm_sec_i,
  input logic [BYTE_W-1:0] alm_min_i,
  input logic [BYTE_W-1:0] alm_hour_i,
  input logic              alarm_o
);
  logic all_dc;
  logic same_bytes;
  assign all_dc = is_dont_care(alm_sec_i) & is_dont_care(alm_min_i) & is_dont_care(alm_hour_i);
  assign same_bytes = (cur_sec_i == alm_sec_i) && (cur_min_i == alm_min_i) && (cur_hour_i == alm_hour_i);

  AST_NO_TICK_NO_ALARM: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> !alarm_o); // R1
  AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (rst)
    freeze_i |=> !alarm_o); // R8
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    div_hold_i |=> !alarm_o); // R9
  AST_ALL_DC_FIRES: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !freeze_i && !div_hold_i && all_dc) |=> alarm_o); // R12
  AST_BIN_EQUAL_FIRES: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !freeze_i && !div_hold_i && bin_mode_i && same_bytes) |=> alarm_o); // R4
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .freeze_i(freeze_i),
  .div_hold_i(div_hold_i), .bin_mode_i(bin_mode_i),
  .cur_sec_i(cur_sec_i), .cur_min_i(cur_min_i), .cur_hour_i(cur_hour_i),
  .alm_sec_i(alm_sec_i), .alm_min_i(alm_min_i), .alm_hour_i(alm_hour_i),
  .alarm_o(alarm_o)
);

// File: tb/rtc_alarm_match_test.sv
module rtc_alarm_match_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0, freeze_i = 1'b0, div_hold_i = 1'b0;
  logic bin_mode_i = 1'b0, hr24_i = 1'b1;
  logic [7:0] cur_sec_i = '0, cur_min_i = '0, cur_hour_i = '0;
  logic [7:0] alm_sec_i = '0, alm_min_i = '0, alm_hour_i = '0;
  logic alarm_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rtc_alarm_match uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .freeze_i(freeze_i),
    .div_hold_i(div_hold_i), .bin_mode_i(bin_mode_i), .hr24_i(hr24_i),
    .cur_sec_i(cur_sec_i), .cur_min_i(cur_min_i), .cur_hour_i(cur_hour_i),
    .alm_sec_i(alm_sec_i), .alm_min_i(alm_min_i), .alm_hour_i(alm_hour_i),
    .alarm_o(alarm_o)
  );

  // {bin, hr24, cur s/m/h, alarm s/m/h, expected, requirement number}
  localparam int NV = 16;
  localparam logic [54:0] VEC [NV] = '{
    {1'b0,1'b1,8'h30,8'h45,8'h13,8'h30,8'h45,8'h13,1'b1,4'd3},  // R3 exact BCD
    {1'b0,1'b1,8'h30,8'h45,8'h13,8'h31,8'h45,8'h13,1'b0,4'd3},  // R3 seconds differ
    {1'b1,1'b1,8'h3B,8'h3B,8'h17,8'h3B,8'h3B,8'h17,1'b1,4'd4},  // R4 binary equal
    {1'b1,1'b1,8'h3B,8'h3B,8'h17,8'h3A,8'h3B,8'h17,1'b0,4'd4},  // R4 binary differ
    {1'b0,1'b1,8'h22,8'h22,8'h08,8'h22,8'hC0,8'h08,1'b1,4'd2},  // R2 minute don't-care
    {1'b0,1'b0,8'h05,8'h10,8'h85,8'h05,8'h10,8'hFF,1'b1,4'd2},  // R2 hour 0xFF in 12h
    {1'b0,1'b1,8'h05,8'h10,8'h08,8'h80,8'h10,8'h08,1'b0,4'd2},  // R2 bit7 alone is 80
    {1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,8'h00,8'h12,1'b1,4'd5},  // R5 12AM == 0
    {1'b0,1'b0,8'h00,8'h00,8'h81,8'h00,8'h00,8'h01,1'b0,4'd5},  // R5 1PM != 1AM
    {1'b1,1'b0,8'h00,8'h00,8'h8C,8'h00,8'h00,8'h8C,1'b1,4'd5},  // R5 bin 12PM
    {1'b1,1'b0,8'h00,8'h00,8'h8C,8'h00,8'h00,8'h0C,1'b0,4'd5},  // R5 12PM != 12AM
    {1'b0,1'b1,8'h00,8'h00,8'h12,8'h00,8'h00,8'h00,1'b0,4'd6},  // R6 24h: 12 != 0
    {1'b0,1'b1,8'h1A,8'h00,8'h00,8'h1A,8'h00,8'h00,1'b0,4'd7},  // R7 bad units digit
    {1'b1,1'b1,8'h1A,8'h00,8'h00,8'h1A,8'h00,8'h00,1'b1,4'd7},  // R7 same bytes binary
    {1'b0,1'b1,8'h00,8'hA0,8'h00,8'h00,8'hA0,8'h00,1'b0,4'd7},  // R7 bad tens digit
    {1'b0,1'b1,8'h47,8'h59,8'h23,8'hC0,8'hC0,8'hC0,1'b1,4'd12}  // R12 all don't-care
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: alarm_o=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] cs, input logic [7:0] cm, input logic [7:0] ch,
                          input logic [7:0] as, input logic [7:0] am, input logic [7:0] ah);
    cur_sec_i = cs; cur_min_i = cm; cur_hour_i = ch;
    alm_sec_i = as; alm_min_i = am; alm_hour_i = ah;
  endtask

  // tick for one cycle; alarm_o changes on the edge that captures the tick
  task automatic pulse(input string tag, input logic exp);
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    check(tag, alarm_o, exp);
    @(negedge clk);
    check({tag, " R1 single cycle"}, alarm_o, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11 reset state, and reset dominates a matching tick
    set_time(8'h01, 8'h02, 8'h03, 8'hC0, 8'hC0, 8'hC0);
    tick_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 held in reset", alarm_o, 1'b0);
    tick_i = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R11 after reset", alarm_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      v = VEC[i];
      bin_mode_i = v[54];
      hr24_i     = v[53];
      set_time(v[52:45], v[44:37], v[36:29], v[28:21], v[20:13], v[12:5]);
      pulse($sformatf("R%0d vector %0d", v[3:0], i), v[4]);
    end

    // R1 matching inputs without a tick give nothing
    bin_mode_i = 1'b0; hr24_i = 1'b1;
    set_time(8'h10, 8'h20, 8'h08, 8'h10, 8'h20, 8'h08);
    repeat (2) @(negedge clk);
    check("R1 no tick", alarm_o, 1'b0);

    // R8 freeze suppresses, R9 prescaler hold suppresses
    set_time(8'h10, 8'h20, 8'h08, 8'hC0, 8'hC0, 8'hC0);
    freeze_i = 1'b1;
    pulse("R8 frozen", 1'b0);
    freeze_i = 1'b0;
    div_hold_i = 1'b1;
    pulse("R9 divider held", 1'b0);
    div_hold_i = 1'b0;
    pulse("R12 released", 1'b1);

    // R10 seconds don't-care within a fixed minute
    set_time(8'h00, 8'h20, 8'h10, 8'hC0, 8'h20, 8'h10);
    pulse("R10 second 00", 1'b1);
    cur_sec_i = 8'h01;
    pulse("R10 second 01", 1'b1);
    cur_sec_i = 8'h59;
    pulse("R10 second 59", 1'b1);
    cur_sec_i = 8'h00; cur_min_i = 8'h21;
    pulse("R10 next minute", 1'b0);

    // R11 reset mid-run clears a pending event
    set_time(8'h00, 8'h00, 8'h00, 8'hC0, 8'hC0, 8'hC0);
    @(negedge clk);
    tick_i = 1'b1; rst = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; rst = 1'b0;
    check("R11 reset with tick", alarm_o, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule